// File: doc/BRIEF.md
# Shadowed Lockable Nonvolatile Memory Controller

This block owns a 256-byte byte-addressed map with two 16-byte nonvolatile blocks (20h–2Fh and 30h–3Fh) and a 16-byte scratch SRAM (80h–8Fh). Every access to a nonvolatile address touches a shadow RAM copy. The persistent array changes only through an explicit copy command, and it is read back only through a recall command. The array is modelled as a register array. A copy holds a busy flag for a programmable number of cycles. Each block can be made permanently read-only by a lock command, which takes effect only after a separate arming write.

Write data arrives one bit at a time, least significant bit first, from a serial front end. A byte is stored only when its eighth bit has arrived. Reads return one byte on the cycle after the request. A pair of measurement bytes at 0Ch/0Dh is latched coherently for the duration of one read command. A live control byte sits at 00h and a read-only configuration field at 01h. A recall of block 1 reloads both of them from the stored defaults.

Top module: `nvmem_ctrl`

## Requirements
- R1: A byte written to 20h–3Fh or 80h–8Fh (block unlocked, not busy) reads back at the same address; 00h is a plain read/write byte.
- R2: A write to an address in a locked block leaves the shadow byte unchanged.
- R3: Copy on an address in an unlocked block moves all 16 shadow bytes of that block into the array when busy ends; copy on a locked block does nothing and raises no busy.
- R4: An accepted copy sets nv_busy from the next cycle for exactly PROG_CYCLES cycles; nonvolatile writes committed while busy are dropped, SRAM writes still land.
- R5: Recall replaces the 16 shadow bytes of the addressed block with the array contents, locked or not.
- R6: Lock sets the block's lock flag only when the arm bit (07h bit 6, writable) is 1; the arm bit then clears; a flag once set stays set until reset.
- R7: Byte 07h reads {busy, arm, 0000, lock1, lock0} (busy bit 7, arm bit 6, block 1 flag bit 1, block 0 flag bit 0); its other bits ignore writes.
- R8: Reading 0Ch returns meas_word[15:8] and captures meas_word[7:0]; a later 0Dh read in the same read command (until rd_start) returns the captured byte, otherwise the live one.
- R9: Addresses 100h and above read FFh and ignore writes; reserved addresses read 00h and ignore writes; 01h ignores writes.
- R10: Recall of block 1 loads bits 1:0 of stored byte 30h into 00h bits 1:0 and bits 5:3 of stored byte 31h into 01h bits 5:3.
- R11: A write byte is stored only after its 8th serial bit; a bus_reset mid-byte discards the partial bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Discards a partly received write byte |
| wr_addr | input | 9 | Target address of the byte being received |
| wr_bit_valid | input | 1 | A serial write bit is present |
| wr_bit | input | 1 | Serial write bit, LSB first |
| rd_start | input | 1 | Marks the start of a new read command |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Read address |
| rd_data | output | 8 | Read byte, valid the cycle after rd_en |
| cmd_valid | input | 1 | Block command strobe |
| cmd_op | input | 2 | 1 copy, 2 recall, 3 lock, 0 none |
| cmd_addr | input | 9 | Any address inside the target block |
| meas_word | input | 16 | Live two-byte measurement value |
| nv_busy | output | 1 | Copy in progress |

## Verification
The properties assume that cmd_valid, rd_en and the serial write strobe are never asserted in the same cycle in ways that conflict. They also assume that wr_addr stays stable from the first bit of a byte until the byte is committed. The busy-window and lock checks rely on commands being ignored while a copy is running. The stimulus issues one operation at a time and holds each address through its full transfer. It overlaps only writes with a running copy, since that overlap is the case under test.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_COPY   = 2'd1,
        OP_RECALL = 2'd2,
        OP_LOCK   = 2'd3
    } nvm_op_e;

    localparam int NV_BASE    = 'h20;
    localparam int SRAM_BASE  = 'h80;
    localparam int MAP_BYTES  = 256;
    localparam int A_CTRL     = 'h00;
    localparam int A_CFG      = 'h01;
    localparam int A_NVSTAT   = 'h07;
    localparam int A_PAIR_HI  = 'h0C;
    localparam int A_PAIR_LO  = 'h0D;
    // stored defaults live in the first two bytes of block 1
    localparam int DFLT_CTRL_OFF = 'h10;
    localparam int DFLT_CFG_OFF  = 'h11;
endpackage

// File: rtl/nvm_bit_rx.sv
module nvm_bit_rx #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_reset,
    input  logic                 bit_valid,
    input  logic                 bit_in,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_out
);
    localparam int CNT_W = $clog2(BYTE_BITS);

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_BITS-1:0] sh;
        logic                 vld;
        logic [BYTE_BITS-1:0] data;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.vld = 1'b0;
        if (bus_reset) begin
            rx_d.cnt = '0;
        end else if (bit_valid) begin
            rx_d.sh = {bit_in, rx_q.sh[BYTE_BITS-1:1]};
            if (rx_q.cnt == CNT_W'(BYTE_BITS - 1)) begin
                rx_d.cnt  = '0;
                rx_d.vld  = 1'b1;
                rx_d.data = {bit_in, rx_q.sh[BYTE_BITS-1:1]};
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign byte_valid = rx_q.vld;
    assign byte_out   = rx_q.data;
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.busy) begin
            if (tm_q.cnt == '0) tm_d.busy = 1'b0;
            else                tm_d.cnt  = tm_q.cnt - 1'b1;
        end else if (start) begin
            tm_d.busy = 1'b1;
            tm_d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign busy = tm_q.busy;
    assign done = tm_q.busy && (tm_q.cnt == '0);
endmodule

// File: rtl/nvm_pair_latch.sv
module nvm_pair_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       new_cmd,
    input  logic       capture,
    input  logic [7:0] live_lo,
    output logic [7:0] lo_view
);
    typedef struct packed {
        logic       held;
        logic [7:0] lo;
    } pl_t;

    pl_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (new_cmd) pl_d.held = 1'b0;
        if (capture) begin
            pl_d.held = 1'b1;
            pl_d.lo   = live_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    assign lo_view = pl_q.held ? pl_q.lo : live_lo;
endmodule

// File: rtl/nvmem_ctrl.sv
module nvmem_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int BLK_BYTES   = 16,
    parameter int SRAM_BYTES  = 16,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit_valid,
    input  logic              wr_bit,
    input  logic              rd_start,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [15:0]       meas_word,
    output logic              nv_busy
);
    localparam int NUM_BLK  = 2;
    localparam int NV_BYTES = NUM_BLK * BLK_BYTES;
    localparam int OFF_W    = $clog2(NV_BYTES);
    localparam int BLK_W    = $clog2(BLK_BYTES);
    localparam int BI_W     = OFF_W - BLK_W;
    localparam int SRAM_W   = $clog2(SRAM_BYTES);

    typedef struct packed {
        logic [NV_BYTES-1:0][7:0]   shadow;
        logic [NV_BYTES-1:0][7:0]   array;
        logic [SRAM_BYTES-1:0][7:0] sram;
        logic [7:0]                 ctrl;
        logic [2:0]                 cfg;
        logic                       lock_en;
        logic [NUM_BLK-1:0]         locked;
        logic [BI_W-1:0]            copy_blk;
        logic [7:0]                 rdata;
    } state_t;

    state_t st_d, st_q;

    function automatic logic is_nv(logic [ADDR_W-1:0] a);
        return (a >= ADDR_W'(NV_BASE)) && (a < ADDR_W'(NV_BASE + NV_BYTES));
    endfunction

    function automatic logic is_sram(logic [ADDR_W-1:0] a);
        return (a >= ADDR_W'(SRAM_BASE)) && (a < ADDR_W'(SRAM_BASE + SRAM_BYTES));
    endfunction

    // ---- sub-blocks ----
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       busy, copy_done, copy_go;
    logic       pair_cap;
    logic [7:0] pair_lo;

    nvm_bit_rx #(.BYTE_BITS(8)) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .bit_valid  (wr_bit_valid),
        .bit_in     (wr_bit),
        .byte_valid (byte_valid),
        .byte_out   (byte_data)
    );

    nvm_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (copy_go),
        .busy  (busy),
        .done  (copy_done)
    );

    assign pair_cap = rd_en && (rd_addr == ADDR_W'(A_PAIR_HI));

    nvm_pair_latch i_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .new_cmd (rd_start),
        .capture (pair_cap),
        .live_lo (meas_word[7:0]),
        .lo_view (pair_lo)
    );

    // ---- decode ----
    nvm_op_e          op;
    logic [OFF_W-1:0] cmd_off, wr_off, rd_off;
    logic [BI_W-1:0]  cmd_blk, wr_blk;
    logic [SRAM_W-1:0] wr_soff, rd_soff;

    assign op      = nvm_op_e'(cmd_op);
    assign cmd_off = OFF_W'(cmd_addr - ADDR_W'(NV_BASE));
    assign wr_off  = OFF_W'(wr_addr - ADDR_W'(NV_BASE));
    assign rd_off  = OFF_W'(rd_addr - ADDR_W'(NV_BASE));
    assign cmd_blk = cmd_off[OFF_W-1:BLK_W];
    assign wr_blk  = wr_off[OFF_W-1:BLK_W];
    assign wr_soff = SRAM_W'(wr_addr - ADDR_W'(SRAM_BASE));
    assign rd_soff = SRAM_W'(rd_addr - ADDR_W'(SRAM_BASE));

    always_comb begin
        st_d    = st_q;
        copy_go = 1'b0;

        // block commands, ignored while a copy runs
        if (cmd_valid && !busy && is_nv(cmd_addr)) begin
            case (op)
                OP_COPY: begin
                    if (!st_q.locked[cmd_blk]) begin
                        copy_go       = 1'b1;
                        st_d.copy_blk = cmd_blk;
                    end
                end
                OP_RECALL: begin
                    for (int i = 0; i < BLK_BYTES; i++) begin
                        st_d.shadow[{cmd_blk, BLK_W'(i)}] = st_q.array[{cmd_blk, BLK_W'(i)}];
                    end
                    if (cmd_blk == BI_W'(1)) begin
                        st_d.ctrl[1:0] = st_q.array[DFLT_CTRL_OFF][1:0];
                        st_d.cfg       = st_q.array[DFLT_CFG_OFF][5:3];
                    end
                end
                OP_LOCK: begin
                    if (st_q.lock_en) begin
                        st_d.locked[cmd_blk] = 1'b1;
                        st_d.lock_en         = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        // end of programming: whole block lands in the array
        if (copy_done) begin
            for (int i = 0; i < BLK_BYTES; i++) begin
                st_d.array[{st_q.copy_blk, BLK_W'(i)}] = st_q.shadow[{st_q.copy_blk, BLK_W'(i)}];
            end
        end

        // committed write byte
        if (byte_valid) begin
            if (is_nv(wr_addr)) begin
                if (!busy && !st_q.locked[wr_blk]) st_d.shadow[wr_off] = byte_data;
            end else if (is_sram(wr_addr)) begin
                st_d.sram[wr_soff] = byte_data;
            end else if (wr_addr == ADDR_W'(A_CTRL)) begin
                st_d.ctrl = byte_data;
            end else if (wr_addr == ADDR_W'(A_NVSTAT)) begin
                st_d.lock_en = byte_data[6];
            end
        end

        // read port
        if (rd_en) begin
            if (rd_addr >= ADDR_W'(MAP_BYTES))            st_d.rdata = 8'hFF;
            else if (is_nv(rd_addr))                      st_d.rdata = st_q.shadow[rd_off];
            else if (is_sram(rd_addr))                    st_d.rdata = st_q.sram[rd_soff];
            else if (rd_addr == ADDR_W'(A_CTRL))          st_d.rdata = st_q.ctrl;
            else if (rd_addr == ADDR_W'(A_CFG))           st_d.rdata = {2'b00, st_q.cfg, 3'b000};
            else if (rd_addr == ADDR_W'(A_NVSTAT))
                st_d.rdata = {busy, st_q.lock_en, 4'b0000, st_q.locked};
            else if (rd_addr == ADDR_W'(A_PAIR_HI))       st_d.rdata = meas_word[15:8];
            else if (rd_addr == ADDR_W'(A_PAIR_LO))       st_d.rdata = pair_lo;
            else                                          st_d.rdata = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [NUM_BLK-1:0] lock_flags;
    logic               lock_armed;

    assign lock_flags = st_q.locked;
    assign lock_armed = st_q.lock_en;
    assign rd_data    = st_q.rdata;
    assign nv_busy    = busy;
endmodule

// File: rtl/nvmem_ctrl_chk.sv
module nvmem_ctrl_chk #(
    parameter int ADDR_W      = 9,
    parameter int PROG_CYCLES = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              nv_busy,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [1:0]        lock_flags,
    input logic              lock_armed
);
    logic in_blocks;
    logic blk_sel;
    int   run_q;

    assign in_blocks = (cmd_addr >= ADDR_W'('h20)) && (cmd_addr <= ADDR_W'('h3F));
    assign blk_sel   = cmd_addr[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= 0;
        else if (nv_busy) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r4_busy_bounded: assert (run_q <= PROG_CYCLES)
                else $error("busy longer than programming window");
        end
    end

    a_r4_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && !nv_busy && in_blocks && !lock_flags[blk_sel]) |=> nv_busy);

    a_r3_locked_copy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && !nv_busy && in_blocks && lock_flags[blk_sel]) |=> !nv_busy);

    a_r9_high_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[ADDR_W-1]) |=> (rd_data == 8'hFF));

    a_r6_lock0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flags[0] |=> lock_flags[0]);

    a_r6_lock1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flags[1] |=> lock_flags[1]);

    a_r6_lock_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_flags[0]) || $rose(lock_flags[1])) |-> ($past(lock_armed) && !lock_armed));
endmodule

bind nvmem_ctrl nvmem_ctrl_chk #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .nv_busy    (nv_busy),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .lock_flags (lock_flags),
    .lock_armed (lock_armed)
);

// File: tb/test_nvmem_ctrl.sv
module test_nvmem_ctrl;
    localparam int PROG = 20;
    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_CP = 3'd2, K_RC = 3'd3, K_LK = 3'd4;
    localparam int NV = 37;

    // {kind, addr, data/expect, requirement}
    localparam logic [23:0] VEC [NV] = '{
        {K_WR, 9'h020, 8'hA5, 4'd1},
        {K_WR, 9'h02F, 8'h3C, 4'd1},
        {K_WR, 9'h030, 8'h02, 4'd10},
        {K_WR, 9'h031, 8'h28, 4'd10},
        {K_WR, 9'h085, 8'h77, 4'd1},
        {K_RD, 9'h020, 8'hA5, 4'd1},   // R1
        {K_RD, 9'h02F, 8'h3C, 4'd1},
        {K_RD, 9'h085, 8'h77, 4'd1},
        {K_CP, 9'h020, 8'h01, 4'd3},   // R3 busy expected
        {K_WR, 9'h020, 8'h11, 4'd1},
        {K_RD, 9'h020, 8'h11, 4'd1},
        {K_RC, 9'h027, 8'h00, 4'd5},
        {K_RD, 9'h020, 8'hA5, 4'd5},   // R5 recall restores copied byte
        {K_CP, 9'h03A, 8'h01, 4'd3},
        {K_RC, 9'h030, 8'h00, 4'd10},
        {K_RD, 9'h000, 8'h02, 4'd10},  // R10 ctrl bits 1:0
        {K_RD, 9'h001, 8'h28, 4'd10},  // R10 cfg bits 5:3
        {K_WR, 9'h020, 8'h11, 4'd1},
        {K_LK, 9'h020, 8'h00, 4'd6},
        {K_RD, 9'h007, 8'h00, 4'd6},   // R6 not armed: no lock
        {K_WR, 9'h007, 8'hC3, 4'd7},
        {K_RD, 9'h007, 8'h40, 4'd7},   // R7 only arm bit writable
        {K_LK, 9'h020, 8'h00, 4'd6},
        {K_RD, 9'h007, 8'h01, 4'd6},   // R6 flag set, arm cleared
        {K_WR, 9'h021, 8'h99, 4'd2},
        {K_RD, 9'h021, 8'h00, 4'd2},   // R2
        {K_RC, 9'h020, 8'h00, 4'd5},
        {K_RD, 9'h020, 8'hA5, 4'd5},   // R5 recall on locked block
        {K_CP, 9'h020, 8'h00, 4'd3},   // R3 locked copy: no busy
        {K_WR, 9'h1FF, 8'h12, 4'd9},
        {K_RD, 9'h1FF, 8'hFF, 4'd9},   // R9
        {K_WR, 9'h00A, 8'h5A, 4'd9},
        {K_RD, 9'h00A, 8'h00, 4'd9},
        {K_WR, 9'h001, 8'hFF, 4'd9},
        {K_RD, 9'h001, 8'h28, 4'd9},
        {K_WR, 9'h000, 8'hC5, 4'd1},
        {K_RD, 9'h000, 8'hC5, 4'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic [8:0] wr_addr = '0;
    logic       wr_bit_valid = 1'b0;
    logic       wr_bit = 1'b0;
    logic       rd_start = 1'b0;
    logic       rd_en = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [8:0] cmd_addr = '0;
    logic [15:0] meas_word = '0;
    logic       nv_busy;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    nvmem_ctrl #(.PROG_CYCLES(PROG)) i_nvmem_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .wr_addr(wr_addr), .wr_bit_valid(wr_bit_valid), .wr_bit(wr_bit),
        .rd_start(rd_start), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .meas_word(meas_word), .nv_busy(nv_busy)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic send_bits(input logic [8:0] a, input logic [7:0] d, input int n);
        wr_addr = a;
        for (int i = 0; i < n; i++) begin
            wr_bit_valid = 1'b1;
            wr_bit       = d[i];
            @(negedge clk);
        end
        wr_bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_byte(input logic [8:0] a, output logic [7:0] d);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d     = rd_data;
    endtask

    task automatic issue(input logic [1:0] op, input logic [8:0] a);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    task automatic pulse_rd_start();
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

    initial begin
        logic [7:0] d;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R7, R1)
        read_byte(9'h007, d); check("R7 reset status", d, 8'h00);
        read_byte(9'h020, d); check("R1 reset shadow", d, 8'h00);
        check("R4 reset busy", nv_busy, 1'b0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0] k;
            logic [8:0] a;
            logic [7:0] x;
            string tag;
            k = VEC[v][23:21]; a = VEC[v][20:12]; x = VEC[v][11:4];
            tag = $sformatf("R%0d vec %0d", VEC[v][3:0], v);
            case (k)
                K_WR: send_bits(a, x, 8);
                K_RD: begin read_byte(a, d); check(tag, d, x); end
                K_CP: begin issue(2'd1, a); check(tag, nv_busy, x[0]); wait_idle(); end
                K_RC: issue(2'd2, a);
                K_LK: issue(2'd3, a);
                default: ;
            endcase
        end

        // lock block 1 and confirm persistence (R6, R2)
        send_bits(9'h007, 8'h40, 8);
        issue(2'd3, 9'h03F);
        read_byte(9'h007, d); check("R6 both locked", d, 8'h03);
        send_bits(9'h03F, 8'h99, 8);
        read_byte(9'h03F, d); check("R2 block1 locked write", d, 8'h00);

        // reset clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_byte(9'h007, d); check("R7 status after reset", d, 8'h00);

        // busy window length (R4)
        send_bits(9'h020, 8'h5C, 8);
        issue(2'd1, 9'h020);
        cnt = 0;
        while (nv_busy) begin cnt++; @(negedge clk); end
        check("R4 busy cycles", cnt, PROG);

        // busy visible in status, NV write dropped during busy (R7, R4)
        issue(2'd1, 9'h020);
        read_byte(9'h007, d); check("R7 busy bit", d, 8'h80);
        send_bits(9'h021, 8'hE7, 8);
        check("R4 still busy after write", nv_busy, 1'b1);
        wait_idle();
        read_byte(9'h021, d); check("R4 NV write during busy", d, 8'h00);

        // SRAM write during busy lands (R4)
        issue(2'd1, 9'h020);
        send_bits(9'h08F, 8'h42, 8);
        wait_idle();
        read_byte(9'h08F, d); check("R4 SRAM write during busy", d, 8'h42);

        // partial byte discarded (R11)
        send_bits(9'h086, 8'h0F, 4);
        bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
        send_bits(9'h086, 8'h5A, 8);
        read_byte(9'h086, d); check("R11 byte after partial", d, 8'h5A);
        send_bits(9'h087, 8'hFF, 7);
        bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
        repeat (2) @(negedge clk);
        read_byte(9'h087, d); check("R11 partial never stored", d, 8'h00);

        // two-byte latch (R8)
        meas_word = 16'h1234;
        pulse_rd_start();
        read_byte(9'h00C, d); check("R8 high byte", d, 8'h12);
        meas_word = 16'hABCD;
        read_byte(9'h00D, d); check("R8 held low byte", d, 8'h34);
        pulse_rd_start();
        read_byte(9'h00D, d); check("R8 live low byte", d, 8'hCD);

        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end
endmodule